// File: doc/BRIEF.md
# Multiplexed Byte-Lane Bus Master

This block moves single 16-bit register reads and writes from a host onto an 8-bit multiplexed bus that reaches register peripherals in a companion device. The host presents an 8-bit register address, a read/write flag and, for writes, a 16-bit value under a valid/ready handshake. The block then runs the full bus sequence and returns a one-cycle done pulse with the read value and an error flag.

Every byte on the bus goes through its own phase. All control lines and the lanes are cleared, then the byte is placed on the lanes and strobe is raised. An address byte is tagged by the address-latch line. A value travels high byte first. When the bytes have gone out, chip-select is released and the peripheral's busy line is polled. A read that finds busy high is repeated in full. A write that finds busy high pulses chip-select until busy clears. Every line level is held for a programmable number of clocks. The busy input passes through a two-flop synchronizer, and a poll limit ends a transfer whose busy never clears.

Top module: `lanebus_master`

## Requirements
- R1: Out of reset and while idle, reqReady is high, chip-select (busSelN, active low) is high, strobe and address-latch are low, and the lanes are driven (laneOe=1) with 8'hFF.
- R2: A request is taken only in a cycle where reqReady is high. reqReady stays low until the transfer ends, and a reqValid raised during a transfer has no effect on the bus or on the peripheral.
- R3: Each byte phase opens with a clear step of at least HOLD_CYCLES clocks with busSelN, busStb and busAle low and the lanes at 0 or released. Strobe rises only while busSelN is low.
- R4: An address phase raises busAle and places the address on the lanes before strobe rises. A value phase keeps busAle low. Lanes and busAle do not change in the cycle strobe rises.
- R5: busDir is 0 for a read and 1 for a write. It is set before the address phase and stays constant for the whole transfer.
- R6: A write sends three strobes: the address, then wdata[15:8], then wdata[7:0].
- R7: A read drives the address, then releases the lanes (laneOe=0) and captures two bytes with one strobe each, high byte first. Lane bit i goes to bit i of its byte.
- R8: After the read bytes busSelN rises and busy is sampled. If busy is high, both read bytes are fetched again and only the last pair is returned.
- R9: After a write busSelN rises and busy is sampled. While busy is high, busSelN is driven low and then high again before the next sample. k busy samples give k+1 rising edges of busSelN.
- R10: The end of a transfer gives rspDone high for exactly one cycle, with rspRdata and rspErr valid. rspErr is 0 when busy cleared, and reqReady is high in the next cycle.
- R11: If busy is found high on MAX_POLLS consecutive samples, the transfer ends with rspErr=1 after exactly MAX_POLLS busSelN rises.
- R12: Strobe stays high for at least HOLD_CYCLES clocks. Busy is sampled through a two-flop synchronizer at the end of the chip-select hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle; request taken this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Peripheral register address |
| reqWdata | input | 16 | Write value |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read value, valid with rspDone |
| rspErr | output | 1 | Busy poll limit reached, valid with rspDone |
| busSelN | output | 1 | Chip-select, active low |
| busDir | output | 1 | Transfer direction, 1 = write |
| busStb | output | 1 | Byte strobe |
| busAle | output | 1 | Address-latch marker |
| laneOut | output | 8 | Lane output value |
| laneOe | output | 1 | Lane output enable |
| laneIn | input | 8 | Lane input value |
| busBusy | input | 1 | Peripheral busy, asynchronous |

## Verification
The bench models a peripheral with a register file that decodes strobes, latches addresses and serves read bytes. The model holds busy high for a chosen number of samples, and while a read is held off it advances the register after every sample. A design that keeps the first read attempt therefore returns a stale value, and one that swaps byte order or moves the address marker corrupts the register file. Monitors on the lines catch a byte phase without a full clear step and a strobe held too briefly. Counting chip-select edges exposes a write poll loop that does not pulse chip-select low, and a poll limit that is off by one shows as the wrong edge count or a missing error flag. A request issued in mid-transfer must leave its target register untouched, and the strobe count must not change.

// File: rtl/lanebus_pkg.sv
package lanebus_pkg;
  localparam int LANE_W = 8;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 2 * LANE_W;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    LANE_ONES, LANE_ZERO, LANE_ADDR, LANE_HI, LANE_LO
  } laneSel_e;

  typedef struct packed {
    logic     load;
    logic     capHi;
    logic     capLo;
    logic     selN;
    logic     stb;
    logic     ale;
    logic     dir;
    logic     oe;
    laneSel_e laneSel;
  } lineCmd_t;
endpackage

// File: rtl/lanebus_ctrl.sv
module lanebus_ctrl
  import lanebus_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int MAX_POLLS   = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     busySync,
  output logic     reqReady,
  output logic     rspDone,
  output logic     rspErr,
  output lineCmd_t cmd
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DIR, S_CLR, S_LATCH, S_STRB, S_SELHI, S_SELLO, S_DONE
  } state_e;

  state_e        state, nextState;
  logic [HW-1:0] holdCnt;
  logic [1:0]    phase;
  logic [PW-1:0] pollCnt;
  logic          isWrite, dirQ, errQ;
  logic          stepEnd, addrPhase, driveLanes, lastPoll;
  laneSel_e      byteSel;

  assign stepEnd    = (holdCnt == HW'(HOLD_CYCLES - 1));
  assign addrPhase  = (phase == 2'd0);
  assign driveLanes = addrPhase || isWrite;
  assign lastPoll   = (pollCnt == PW'(MAX_POLLS - 1));
  assign byteSel    = addrPhase ? LANE_ADDR : ((phase == 2'd1) ? LANE_HI : LANE_LO);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (reqValid) nextState = S_DIR;
      S_DIR:   if (stepEnd) nextState = S_CLR;
      S_CLR:   if (stepEnd) nextState = driveLanes ? S_LATCH : S_STRB;
      S_LATCH: if (stepEnd) nextState = S_STRB;
      S_STRB:  if (stepEnd) nextState = (phase == 2'd2) ? S_SELHI : S_CLR;
      S_SELHI: if (stepEnd) begin
        if (!busySync || lastPoll) nextState = S_DONE;
        else                       nextState = isWrite ? S_SELLO : S_CLR;
      end
      S_SELLO: if (stepEnd) nextState = S_SELHI;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      holdCnt <= '0;
      phase   <= 2'd0;
      pollCnt <= '0;
      isWrite <= 1'b0;
      dirQ    <= 1'b1;
      errQ    <= 1'b0;
    end else begin
      state   <= nextState;
      holdCnt <= (nextState != state || state == S_IDLE) ? '0 : holdCnt + 1'b1;
      unique case (state)
        S_IDLE: if (reqValid) begin
          isWrite <= reqWrite;
          dirQ    <= reqWrite;
          phase   <= 2'd0;
          pollCnt <= '0;
          errQ    <= 1'b0;
        end
        S_STRB: if (stepEnd && phase != 2'd2) phase <= phase + 2'd1;
        S_SELHI: if (stepEnd && busySync) begin
          pollCnt <= pollCnt + 1'b1;
          if (lastPoll)      errQ  <= 1'b1;
          else if (!isWrite) phase <= 2'd1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd.load    = (state == S_IDLE) && reqValid;
    cmd.capHi   = (state == S_STRB) && stepEnd && !isWrite && (phase == 2'd1);
    cmd.capLo   = (state == S_STRB) && stepEnd && !isWrite && (phase == 2'd2);
    cmd.selN    = 1'b1;
    cmd.stb     = 1'b0;
    cmd.ale     = 1'b0;
    cmd.dir     = dirQ;
    cmd.oe      = 1'b1;
    cmd.laneSel = LANE_ONES;
    unique case (state)
      S_CLR: begin
        cmd.selN = 1'b0; cmd.oe = driveLanes; cmd.laneSel = LANE_ZERO;
      end
      S_LATCH: begin
        cmd.selN = 1'b0; cmd.ale = addrPhase; cmd.laneSel = byteSel;
      end
      S_STRB: begin
        cmd.selN = 1'b0; cmd.stb = 1'b1; cmd.ale = addrPhase; cmd.oe = driveLanes;
        cmd.laneSel = driveLanes ? byteSel : LANE_ZERO;
      end
      S_SELHI: begin
        cmd.oe = isWrite; cmd.laneSel = LANE_ZERO;
      end
      S_SELLO: begin
        cmd.selN = 1'b0; cmd.oe = isWrite; cmd.laneSel = LANE_ZERO;
      end
      default: ;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign rspDone  = (state == S_DONE);
  assign rspErr   = errQ;
endmodule

// File: rtl/lanebus_dp.sv
module lanebus_dp
  import lanebus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              capHi,
  input  logic              capLo,
  input  laneSel_e          laneSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [LANE_W-1:0] laneIn,
  input  logic              busyAsync,
  output logic [LANE_W-1:0] laneOut,
  output logic [WORD_W-1:0] rdata,
  output logic              busySync
);
  logic [ADDR_W-1:0]      addrQ;
  logic [WORD_W-1:0]      wdataQ;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdata  <= '0;
      syncQ  <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], busyAsync};
      if (load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (capHi) rdata[WORD_W-1:LANE_W] <= laneIn;
      if (capLo) rdata[LANE_W-1:0]      <= laneIn;
    end
  end

  assign busySync = syncQ[SYNC_STAGES-1];

  always_comb begin
    unique case (laneSel)
      LANE_ZERO: laneOut = '0;
      LANE_ADDR: laneOut = LANE_W'(addrQ);
      LANE_HI:   laneOut = wdataQ[WORD_W-1:LANE_W];
      LANE_LO:   laneOut = wdataQ[LANE_W-1:0];
      default:   laneOut = '1;
    endcase
  end
endmodule

// File: rtl/lanebus_master.sv
module lanebus_master
  import lanebus_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int MAX_POLLS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [WORD_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              busSelN,
  output logic              busDir,
  output logic              busStb,
  output logic              busAle,
  output logic [LANE_W-1:0] laneOut,
  output logic              laneOe,
  input  logic [LANE_W-1:0] laneIn,
  input  logic              busBusy
);
  lineCmd_t cmd;
  logic     busySync;

  lanebus_ctrl #(.HOLD_CYCLES(HOLD_CYCLES), .MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busySync(busySync), .reqReady(reqReady), .rspDone(rspDone),
    .rspErr(rspErr), .cmd(cmd)
  );

  lanebus_dp u_dp (
    .clk(clk), .rstN(rstN), .load(cmd.load), .capHi(cmd.capHi),
    .capLo(cmd.capLo), .laneSel(cmd.laneSel), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .laneIn(laneIn), .busyAsync(busBusy),
    .laneOut(laneOut), .rdata(rspRdata), .busySync(busySync)
  );

  assign busSelN = cmd.selN;
  assign busDir  = cmd.dir;
  assign busStb  = cmd.stb;
  assign busAle  = cmd.ale;
  assign laneOe  = cmd.oe;
endmodule

// File: rtl/lanebus_checker.sv
module lanebus_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       rspDone,
  input logic       busSelN,
  input logic       busDir,
  input logic       busStb,
  input logic       busAle,
  input logic [7:0] laneOut,
  input logic       laneOe
);
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busSelN && !busStb && !busAle && laneOe && laneOut == 8'hFF)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R10
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> reqReady); // R2
  AST_STB_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busStb) |-> !busSelN); // R3
  AST_STB_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busStb) |-> ($stable(laneOut) && $stable(busAle))); // R4
  AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> laneOe); // R4
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(busDir)); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && !busAle && !busDir) |-> !laneOe); // R7
endmodule

bind lanebus_master lanebus_checker u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspDone(rspDone),
  .busSelN(busSelN), .busDir(busDir), .busStb(busStb), .busAle(busAle),
  .laneOut(laneOut), .laneOe(laneOe)
);

// File: tb/lanebus_master_bench.sv
module lanebus_master_bench;
  localparam int HOLD = 4;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, rspDone, rspErr;
  logic busSelN, busDir, busStb, busAle, laneOe, busBusy;
  logic [7:0]  reqAddr, laneOut;
  logic [7:0]  laneIn = 8'h00;
  logic [15:0] reqWdata, rspRdata;

  lanebus_master #(.HOLD_CYCLES(HOLD), .MAX_POLLS(MAXP)) u_lanebus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .rspErr(rspErr),
    .busSelN(busSelN), .busDir(busDir), .busStb(busStb), .busAle(busAle),
    .laneOut(laneOut), .laneOe(laneOe), .laneIn(laneIn), .busBusy(busBusy)
  );

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // peripheral model
  logic [15:0] mem [256];
  logic [7:0]  pAddr = 8'h00, hiByte = 8'h00;
  logic        pIdx = 1'b0;
  int          kBusy = 0, riseCount = 0, logN = 0;
  bit          inTxn = 1'b0;
  logic        logAle [64];
  logic        logOe  [64];
  logic        logDir [64];
  logic [7:0]  logVal [64];

  assign busBusy = inTxn && (riseCount <= kBusy);

  always @(posedge busStb) begin
    if (logN < 64) begin
      logAle[logN] = busAle; logOe[logN] = laneOe;
      logDir[logN] = busDir; logVal[logN] = laneOut;
    end
    logN++;
    if (busAle) begin
      pAddr = laneOut; pIdx = 1'b0;
    end else if (busDir) begin
      if (!pIdx) hiByte = laneOut;
      else       mem[pAddr] = {hiByte, laneOut};
      pIdx = ~pIdx;
    end else begin
      laneIn = pIdx ? mem[pAddr][7:0] : mem[pAddr][15:8];
      pIdx = ~pIdx;
    end
  end

  always @(posedge busSelN) begin
    if (inTxn) begin
      if (!busDir && (riseCount + 1 <= kBusy)) mem[pAddr] = mem[pAddr] + 16'h0101;
      riseCount++;
    end
  end

  // line monitors for R3 and R12
  int clrRun = 0, lastRun = 0, stbRun = 0;
  bit seenClr = 1'b0, prevStb = 1'b0, clrNow;
  always @(negedge clk) begin
    if (rstN) begin
      clrNow = !busSelN && !busStb && !busAle && (!laneOe || laneOut == 8'h00);
      if (clrNow) clrRun++;
      else begin
        if (clrRun > 0) begin lastRun = clrRun; seenClr = 1'b1; end
        clrRun = 0;
      end
      if (busStb && !prevStb) begin
        check("R3 clear step before strobe", 32'(seenClr && lastRun >= HOLD), 1);
        seenClr = 1'b0;
      end
      if (busStb) stbRun++;
      else begin
        if (prevStb) check("R12 strobe hold", 32'(stbRun >= HOLD), 1);
        stbRun = 0;
      end
      prevStb = busStb;
    end
  end

  function automatic logic [15:0] expRead(input logic [15:0] v0, input int k);
    return v0 + 16'(k) * 16'h0101;
  endfunction

  function automatic int expRises(input int k);
    return (k < MAXP) ? k + 1 : MAXP;
  endfunction

  task automatic doTxn(input bit wr, input logic [7:0] a, input logic [15:0] d,
                       input int k, input bit poke,
                       output logic [15:0] rd, output logic er);
    int n;
    kBusy = k; riseCount = 0; logN = 0; pIdx = 1'b0; inTxn = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = 16'($urandom); reqAddr = 8'($urandom);
    check("R2 ready low in transfer", 32'(reqReady), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a ^ 8'h55; reqWdata = 16'hDEAD;
      @(negedge clk);
      reqValid = 1'b0;
    end
    n = 0;
    while (!rspDone && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check("R10 completion seen", 0, 1);
    rd = rspRdata; er = rspErr;
    @(negedge clk);
    check("R10 done lasts one cycle", 32'(rspDone), 0);
    check("R2 ready after done", 32'(reqReady), 1);
    inTxn = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d, input int k, input bit poke);
    logic [15:0] rd, other;
    logic er;
    other = mem[a ^ 8'h55];
    doTxn(1'b1, a, d, k, poke, rd, er);
    if (k < MAXP) begin
      check("R6 register written", 32'(mem[a]), 32'(d));
      check("R10 no error", 32'(er), 0);
    end else check("R11 timeout error", 32'(er), 1);
    check("R9 chip-select rises", 32'(riseCount), 32'(expRises(k)));
    check("R6 strobe count", 32'(logN), 3);
    check("R4 address marked", {23'd0, logAle[0], logVal[0]}, {23'd0, 1'b1, a});
    check("R6 high byte first", {23'd0, logAle[1], logVal[1]}, {23'd0, 1'b0, d[15:8]});
    check("R6 low byte second", {23'd0, logAle[2], logVal[2]}, {23'd0, 1'b0, d[7:0]});
    check("R5 direction write", {29'd0, logDir[0], logDir[1], logDir[2]}, 32'h7);
    if (poke) check("R2 mid-transfer request ignored", 32'(mem[a ^ 8'h55]), 32'(other));
  endtask

  task automatic doRead(input logic [7:0] a, input int k);
    logic [15:0] rd, v0;
    logic er;
    int tries;
    v0 = mem[a];
    tries = expRises(k);
    doTxn(1'b0, a, 16'h0000, k, 1'b0, rd, er);
    if (k < MAXP) begin
      check("R8 final attempt value", 32'(rd), 32'(expRead(v0, k)));
      check("R10 no error", 32'(er), 0);
    end else check("R11 timeout error", 32'(er), 1);
    check("R7 strobe count", 32'(logN), 32'(1 + 2 * tries));
    check("R4 address marked", {23'd0, logAle[0], logVal[0]}, {23'd0, 1'b1, a});
    check("R7 lanes released", {30'd0, logOe[1], logOe[2]}, 0);
    check("R5 direction read", {30'd0, logDir[0], logDir[1]}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("R10 watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic er;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0103);
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = 8'h00; reqWdata = 16'h0000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready at reset", 32'(reqReady), 1);
    check("R1 select idle high", 32'(busSelN), 1);
    check("R1 strobe and latch low", {30'd0, busStb, busAle}, 0);
    check("R1 lanes driven high", {23'd0, laneOe, laneOut}, 32'h1FF);
    check("R10 no done at reset", 32'(rspDone), 0);

    doWrite(8'h12, 16'hA55A, 0, 1'b0);
    doRead(8'h12, 0);
    mem[8'h3C] = 16'h8001;
    doRead(8'h3C, 0);
    check("R7 bit mapping", 32'(mem[8'h3C]), 32'h8001);
    doWrite(8'h40, 16'h1234, 3, 1'b0);
    doRead(8'h40, 2);
    doWrite(8'h77, 16'hBEEF, 1, 1'b1);
    doWrite(8'h81, 16'h0F0F, MAXP - 1, 1'b0);
    doRead(8'h90, MAXP - 1);
    doWrite(8'hA0, 16'h5555, MAXP + 4, 1'b0);
    doRead(8'hA1, MAXP + 4);
    doTxn(1'b0, 8'h12, 16'h0, 0, 1'b0, rd, er);
    check("R12 read after timeouts", 32'(rd), 32'hA55A);

    for (int t = 0; t < 40; t++) begin
      if ($urandom % 2) doWrite(8'($urandom), 16'($urandom), int'($urandom % 3), 1'b0);
      else              doRead(8'($urandom), int'($urandom % 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule